// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the scan timing for a display output from a single pixel clock. A pixel counter runs across each line and a line counter runs down each frame. Compare logic then derives a data-enable window, a horizontal and a vertical sync pulse, and a field flag for interlaced scanning. The polarity of each sync pulse is set separately. The current pixel and line positions are also driven out, so that a neighbouring fetch engine can follow the raster.

Software configures the block through six word registers on a simple write/read port. The fields do not all use the same encoding. Horizontal total, horizontal active and horizontal sync-start are each stored as their value minus one. Horizontal sync-end is stored raw. Vertical total and vertical active are each stored as the line count minus one. Both vertical sync fields are stored as raw line numbers.

A vertical-blank status bit sets at the start of vertical blanking and is cleared by writing 1 to it. An enable bit gates that status onto the interrupt line. A separate output-enable register gates the analog output path.

Top module: `raster_timing_gen`

## Requirements
- R1: Registers are selected by `reg_addr_i`, and a read returns the stored value combinationally. The addresses are: 0 control, 1 output enable (bit 0), 2 horizontal timing A, 3 horizontal timing B, 4 vertical timing A, 5 vertical timing B. In each timing register the first field sits in bits [CW-1:0] and the second in bits [16+CW-1:16]. A = total-1 / active-1 (horizontal) or total-1 / active-1 (vertical). B = sync-start-1 / sync-end (horizontal) or sync-start / sync-end (vertical). The control bits are: bit 0 run, bit 1 interlace, bit 2 hsync negative, bit 3 vsync negative, bit 4 interrupt enable, bit 5 vertical-blank status. All registers reset to 0.
- R2: While running, `x_o` counts 0 up to the horizontal total field and then wraps to 0. A line therefore lasts field+1 clocks.
- R3: `y_o` advances by one on each horizontal wrap. It wraps to 0 after the line equal to the vertical total field.
- R4: `de_o` is 1 exactly when the block is running, `x_o` is at most the horizontal active field, and `y_o` is at most the vertical active field.
- R5: The horizontal sync is active while the horizontal sync-start field < `x_o` < the horizontal sync-end field.
- R6: In progressive mode, and in the first field of interlaced mode, the vertical sync is active while the vertical sync-start field <= `y_o` < the vertical sync-end field.
- R7: Each sync output is active-high when its negative-polarity bit is 0 and active-low when it is 1.
- R8: In interlaced mode, `field_o` toggles at every frame wrap; in progressive mode it is 0. In field 1, both vsync edges move half a line later, with half = (horizontal total field + 1) >> 1. Vsync is then active from (line = start, pixel = half) up to, but not including, (line = end, pixel = half).
- R9: While the run bit is 0, `x_o`, `y_o` and `field_o` are 0, `de_o` is 0, and both syncs sit at their inactive level.
- R10: The status bit sets on the clock edge that moves the counters off the last pixel of the last active line. It is therefore visible at (x = 0, y = vertical active field + 1).
- R11: Writing the control register with bit 5 = 1 clears the status bit. A set in the same cycle wins over the clear.
- R12: `irq_o` equals status AND interrupt enable.
- R13: `dac_en_o` equals the output-enable bit AND the run bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| x_o | output | CW | Current pixel column |
| y_o | output | CW | Current line |
| field_o | output | 1 | Interlace field flag |
| de_o | output | 1 | Data enable |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| irq_o | output | 1 | Vertical-blank interrupt |
| dac_en_o | output | 1 | Analog output enable |

## Verification
On every cycle, the assertions check four things: the counters' wrap and advance rules, the idle state when the run bit is clear, the field toggle at each frame wrap, and the status bit's set and write-1-clear priority. They also check that `de_o` and `irq_o` never rise outside their gating conditions. Only the bench's scenarios show that the exact sync windows come out right. Those scenarios cover the minus-one against raw field offsets, the half-line shift of the second field's vsync, the polarity inversions, and a clear that collides with a set. For these, the bench compares every output on every cycle against an arithmetic model across several configurations.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  typedef enum logic [2:0] {
    ADDR_CTRL = 3'd0,
    ADDR_OUT  = 3'd1,
    ADDR_HT_A = 3'd2,
    ADDR_HT_B = 3'd3,
    ADDR_VT_A = 3'd4,
    ADDR_VT_B = 3'd5
  } reg_addr_e;

  localparam int CB_RUN   = 0;
  localparam int CB_ILACE = 1;
  localparam int CB_HNEG  = 2;
  localparam int CB_VNEG  = 3;
  localparam int CB_IRQEN = 4;
  localparam int CB_VBSTS = 5;
  localparam int HI_LSB   = 16;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          vb_set_i,
  output logic          run_o,
  output logic          ilace_o,
  output logic          hneg_o,
  output logic          vneg_o,
  output logic          irq_en_o,
  output logic          vb_sts_o,
  output logic          dac_en_o,
  output logic [CW-1:0] htot_o,
  output logic [CW-1:0] hact_o,
  output logic [CW-1:0] hss_o,
  output logic [CW-1:0] hse_o,
  output logic [CW-1:0] vtot_o,
  output logic [CW-1:0] vact_o,
  output logic [CW-1:0] vss_o,
  output logic [CW-1:0] vse_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  logic ctrl_wr;
  assign ctrl_wr = we_i && (addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o <= 1'b0; ilace_o <= 1'b0; hneg_o <= 1'b0; vneg_o <= 1'b0;
      irq_en_o <= 1'b0; dac_en_o <= 1'b0;
      htot_o <= '0; hact_o <= '0; hss_o <= '0; hse_o <= '0;
      vtot_o <= '0; vact_o <= '0; vss_o <= '0; vse_o <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_CTRL: begin
          run_o    <= wdata_i[CB_RUN];
          ilace_o  <= wdata_i[CB_ILACE];
          hneg_o   <= wdata_i[CB_HNEG];
          vneg_o   <= wdata_i[CB_VNEG];
          irq_en_o <= wdata_i[CB_IRQEN];
        end
        ADDR_OUT:  dac_en_o <= wdata_i[0];
        ADDR_HT_A: begin htot_o <= wdata_i[CW-1:0]; hact_o <= wdata_i[HI_LSB+:CW]; end
        ADDR_HT_B: begin hss_o  <= wdata_i[CW-1:0]; hse_o  <= wdata_i[HI_LSB+:CW]; end
        ADDR_VT_A: begin vtot_o <= wdata_i[CW-1:0]; vact_o <= wdata_i[HI_LSB+:CW]; end
        ADDR_VT_B: begin vss_o  <= wdata_i[CW-1:0]; vse_o  <= wdata_i[HI_LSB+:CW]; end
        default: ;
      endcase
    end
  end

  // set has priority over write-1-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          vb_sts_o <= 1'b0;
    else if (vb_set_i)                    vb_sts_o <= 1'b1;
    else if (ctrl_wr && wdata_i[CB_VBSTS]) vb_sts_o <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CB_RUN]   = run_o;
        rdata_o[CB_ILACE] = ilace_o;
        rdata_o[CB_HNEG]  = hneg_o;
        rdata_o[CB_VNEG]  = vneg_o;
        rdata_o[CB_IRQEN] = irq_en_o;
        rdata_o[CB_VBSTS] = vb_sts_o;
      end
      ADDR_OUT:  rdata_o[0] = dac_en_o;
      ADDR_HT_A: begin rdata_o[CW-1:0] = htot_o; rdata_o[HI_LSB+:CW] = hact_o; end
      ADDR_HT_B: begin rdata_o[CW-1:0] = hss_o;  rdata_o[HI_LSB+:CW] = hse_o;  end
      ADDR_VT_A: begin rdata_o[CW-1:0] = vtot_o; rdata_o[HI_LSB+:CW] = vact_o; end
      ADDR_VT_B: begin rdata_o[CW-1:0] = vss_o;  rdata_o[HI_LSB+:CW] = vse_o;  end
      default: ;
    endcase
  end

  p_sts_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vb_set_i |=> vb_sts_o);
  p_sts_w1c_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wdata_i[CB_VBSTS] && !vb_set_i) |=> !vb_sts_o);
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          ilace_i,
  input  logic [CW-1:0] htot_i,
  input  logic [CW-1:0] vtot_i,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o,
  output logic          field_o
);
  logic line_end, frame_end;
  assign line_end  = (x_o == htot_i);
  assign frame_end = line_end && (y_o == vtot_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o <= '0; y_o <= '0; field_o <= 1'b0;
    end else if (!run_i) begin
      x_o <= '0; y_o <= '0; field_o <= 1'b0;
    end else if (line_end) begin
      x_o <= '0;
      if (frame_end) begin
        y_o     <= '0;
        field_o <= ilace_i ? ~field_o : 1'b0;
      end else begin
        y_o <= y_o + 1'b1;
      end
    end else begin
      x_o <= x_o + 1'b1;
    end
  end

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (x_o == '0 && y_o == '0 && !field_o));
  p_hwrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && x_o == htot_i) |=> x_o == '0);
  p_vadv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && x_o == htot_i && y_o != vtot_i) |=> y_o == $past(y_o) + 1'b1);
  p_field_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && ilace_i && x_o == htot_i && y_o == vtot_i) |=> field_o != $past(field_o));
endmodule

// File: rtl/rtg_decode.sv
module rtg_decode #(
  parameter int CW = 12
) (
  input  logic          run_i,
  input  logic          ilace_i,
  input  logic          hneg_i,
  input  logic          vneg_i,
  input  logic [CW-1:0] x_i,
  input  logic [CW-1:0] y_i,
  input  logic          field_i,
  input  logic [CW-1:0] htot_i,
  input  logic [CW-1:0] hact_i,
  input  logic [CW-1:0] hss_i,
  input  logic [CW-1:0] hse_i,
  input  logic [CW-1:0] vact_i,
  input  logic [CW-1:0] vss_i,
  input  logic [CW-1:0] vse_i,
  output logic          de_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          vb_set_o
);
  logic [CW:0]   line_len;
  logic [CW-1:0] half;
  logic          h_act, v_act, v_act_f0, v_act_f1;

  assign line_len = {1'b0, htot_i} + 1'b1;
  assign half     = line_len[CW:1];

  assign de_o  = run_i && (x_i <= hact_i) && (y_i <= vact_i);
  // start field is stored minus one, end field raw
  assign h_act = run_i && (x_i > hss_i) && (x_i < hse_i);

  assign v_act_f0 = (y_i >= vss_i) && (y_i < vse_i);
  assign v_act_f1 = ((y_i > vss_i) || (y_i == vss_i && x_i >= half)) &&
                    ((y_i < vse_i) || (y_i == vse_i && x_i < half));
  assign v_act    = run_i && ((ilace_i && field_i) ? v_act_f1 : v_act_f0);

  assign hsync_o  = h_act ^ hneg_i;
  assign vsync_o  = v_act ^ vneg_i;
  assign vb_set_o = run_i && (x_i == htot_i) && (y_i == vact_i);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o,
  output logic          field_o,
  output logic          de_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          irq_o,
  output logic          dac_en_o
);
  logic run, ilace, hneg, vneg, irq_en, vb_sts, dac_en, vb_set;
  logic [CW-1:0] htot, hact, hss, hse, vtot, vact, vss, vse;

  rtg_regs #(.CW(CW)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .vb_set_i(vb_set),
    .run_o(run), .ilace_o(ilace), .hneg_o(hneg), .vneg_o(vneg),
    .irq_en_o(irq_en), .vb_sts_o(vb_sts), .dac_en_o(dac_en),
    .htot_o(htot), .hact_o(hact), .hss_o(hss), .hse_o(hse),
    .vtot_o(vtot), .vact_o(vact), .vss_o(vss), .vse_o(vse)
  );

  rtg_counters #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .run_i(run), .ilace_i(ilace), .htot_i(htot), .vtot_i(vtot),
    .x_o, .y_o, .field_o
  );

  rtg_decode #(.CW(CW)) u_dec (
    .run_i(run), .ilace_i(ilace), .hneg_i(hneg), .vneg_i(vneg),
    .x_i(x_o), .y_i(y_o), .field_i(field_o),
    .htot_i(htot), .hact_i(hact), .hss_i(hss), .hse_i(hse),
    .vact_i(vact), .vss_i(vss), .vse_i(vse),
    .de_o, .hsync_o, .vsync_o, .vb_set_o(vb_set)
  );

  assign irq_o    = vb_sts & irq_en;
  assign dac_en_o = dac_en & run;

  p_de_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (x_o <= hact && y_o <= vact));
  p_sync_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (hsync_o == hneg && vsync_o == vneg && !de_o));
  p_irq_gate_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en && vb_sts));
endmodule

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [CW-1:0] x, y;
  logic          field, de, hsync, vsync, irq, dac_en;

  always #10 clk = ~clk;

  raster_timing_gen #(.CW(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .x_o(x), .y_o(y),
    .field_o(field), .de_o(de), .hsync_o(hsync), .vsync_o(vsync),
    .irq_o(irq), .dac_en_o(dac_en)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  int m_run, m_il, m_hn, m_vn, m_ie, m_sts, m_dac;
  int m_htot, m_hact, m_hss, m_hse, m_vtot, m_vact, m_vss, m_vse;
  int mx, my, mf;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_vs_act();
    int half;
    if (!m_run) return 0;
    if (m_il && mf) begin
      half = (m_htot + 1) >> 1;
      return int'(((my > m_vss) || (my == m_vss && mx >= half)) &&
                  ((my < m_vse) || (my == m_vse && mx < half)));
    end
    return int'(my >= m_vss && my < m_vse);
  endfunction

  task automatic check_outs();
    int de_e, hs_e;
    de_e = int'(m_run && mx <= m_hact && my <= m_vact);
    hs_e = int'(m_run && mx > m_hss && mx < m_hse);
    chk("R2 R9 x", int'(x), mx);
    chk("R3 R9 y", int'(y), my);
    chk("R8 field", int'(field), mf);
    chk("R4 de", int'(de), de_e);
    chk("R5 R7 hsync", int'(hsync), hs_e ^ m_hn);
    chk("R6 R7 R8 vsync", int'(vsync), exp_vs_act() ^ m_vn);
    chk("R10 R12 irq", int'(irq), m_sts & m_ie);
    chk("R13 dac_en", int'(dac_en), m_dac & m_run);
  endtask

  task automatic tick();
    bit we_c; int a_c; logic [31:0] d_c; bit set;
    we_c = reg_we; a_c = int'(reg_addr); d_c = reg_wdata;
    @(posedge clk);
    set = m_run && mx == m_htot && my == m_vact;
    if (!m_run) begin mx = 0; my = 0; mf = 0; end
    else if (mx == m_htot) begin
      mx = 0;
      if (my == m_vtot) begin my = 0; mf = m_il ? 1 - mf : 0; end
      else my++;
    end else mx++;
    if (set) m_sts = 1;
    else if (we_c && a_c == 0 && d_c[5]) m_sts = 0;
    if (we_c) begin
      case (a_c)
        0: begin m_run = d_c[0]; m_il = d_c[1]; m_hn = d_c[2]; m_vn = d_c[3]; m_ie = d_c[4]; end
        1: m_dac = d_c[0];
        2: begin m_htot = d_c[11:0]; m_hact = d_c[27:16]; end
        3: begin m_hss = d_c[11:0]; m_hse = d_c[27:16]; end
        4: begin m_vtot = d_c[11:0]; m_vact = d_c[27:16]; end
        5: begin m_vss = d_c[11:0]; m_vse = d_c[27:16]; end
        default: ;
      endcase
    end
    @(negedge clk);
    reg_we = 1'b0;
    check_outs();
  endtask

  task automatic wr(int a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    tick();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  function automatic int model_ctrl();
    return m_run | (m_il << 1) | (m_hn << 2) | (m_vn << 3) | (m_ie << 4) | (m_sts << 5);
  endfunction

  task automatic rd_chk(string tag, int a, int exp);
    reg_addr = 3'(a);
    #1;
    chk(tag, int'(reg_rdata), exp);
  endtask

  function automatic logic [31:0] pk(int lo, int hi);
    return (32'(hi) << 16) | 32'(lo);
  endfunction

  task automatic config_timing(int ht, int ha, int hs, int he, int vt, int va, int vs, int ve);
    wr(2, pk(ht, ha)); wr(3, pk(hs, he)); wr(4, pk(vt, va)); wr(5, pk(vs, ve));
    rd_chk("R1 ht_a", 2, int'(pk(ht, ha)));
    rd_chk("R1 ht_b", 3, int'(pk(hs, he)));
    rd_chk("R1 vt_a", 4, int'(pk(vt, va)));
    rd_chk("R1 vt_b", 5, int'(pk(vs, ve)));
  endtask

  task automatic run_until_vb_edge();
    for (int i = 0; i < 5000; i++) begin
      if (mx == m_htot && my == m_vact) return;
      tick();
    end
    chk("R10 reach vblank edge", 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    {m_run, m_il, m_hn, m_vn, m_ie, m_sts, m_dac} = '{default: 0};
    {m_htot, m_hact, m_hss, m_hse, m_vtot, m_vact, m_vss, m_vse} = '{default: 0};
    mx = 0; my = 0; mf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check_outs();
    rd_chk("R1 reset ctrl", 0, 0);
    rd_chk("R1 reset ht_a", 2, 0);

    // config A: 10 px/line, 8 lines
    config_timing(9, 5, 6, 9, 7, 4, 5, 7);
    wr(1, 32'h1);
    rd_chk("R1 out reg", 1, 1);
    wr(0, 32'h11);               // run + irq enable
    run(170);
    rd_chk("R10 status visible", 0, model_ctrl());
    wr(0, 32'h31);               // W1C
    rd_chk("R11 cleared", 0, model_ctrl());
    chk("R11 status bit low", int'(reg_rdata[5]), 0);

    // negative polarities
    wr(0, 32'h0D);
    run(90);

    // disable mid-frame, then resume
    run(13);
    wr(0, 32'h00);
    run(6);
    wr(0, 32'h11);
    run(85);

    // set wins over simultaneous clear
    run_until_vb_edge();
    wr(0, 32'h31);
    chk("R11 set wins", int'(irq), 1);
    rd_chk("R11 set wins readback", 0, model_ctrl());

    // irq enable off while status set
    wr(0, 32'h01);
    chk("R12 gated off", int'(irq), 0);
    run(40);

    // interlace on config A
    wr(0, 32'h13);
    run(340);

    // config B: odd line length, sync at line 0, interlaced
    wr(0, 32'h00);
    config_timing(10, 7, 0, 3, 5, 2, 0, 1);
    wr(0, 32'h33);
    run(300);
    wr(0, 32'h3B);
    run(150);
    wr(1, 32'h0);
    run(20);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule